// File: doc/BRIEF.md
# Packet-Driven LED Blanking Controller

This block is the packet front end and output-timing core of one device in a daisy chain of multi-channel LED drivers. A host shifts 32-bit packets in on a serial data/clock pair. The block forwards every bit to the next device two serial bits later, and it acts only on packets whose address field matches its own device ID. Write packets load a staged grayscale value for one channel. A synchronisation packet first blanks every output part-way through the packet. At the end of the packet it copies the staged values of the flagged channels into their active registers. It then releases the outputs in step with a separate grayscale clock. A force-on command overrides the blanking and the grayscale timing.

The serial clock, the serial data and the grayscale clock are all asynchronous to the block clock. Each passes through a synchroniser and is edge-detected in the block-clock domain, so the block clock must run several times faster than either of them. A pause in the serial clock longer than a set number of block-clock cycles restarts packet framing. A partial packet therefore cannot misalign the packets that follow it. Each channel's output is a logic enable: it is on for as many grayscale-clock periods as the channel's active value.

Packet layout, in shift order (bit 1 first, bit 32 last): bits 1-8 are the target ID, bits 9-12 are the command, bits 13-20 are an argument byte, and bits 21-32 are the payload. Bit 32 is the payload LSB. The commands are 1 (sync), 2 (write) and 3 (force), and any other value is ignored. The ID 0xFF never matches.

Top module: `ledblank_ctrl`

## Requirements
- R1: While reset is asserted and in the cycle after it, blank_o is 1, led_o is all zeros and sout is 0.
- R2: After each serial-clock rising edge k, sout carries the bit that was sampled at edge k-1, so a downstream device sampling on its own rising edges sees every bit two serial bits late.
- R3: For a sync packet (command 1) addressed to this device, blank_o rises after the falling serial-clock edge that ends bit 21, and not at that bit's rising edge. All led_o bits go to 0 at that point unless force-on is active.
- R4: When bit 32 of that sync packet is received, each channel i whose payload bit i (packet bit 32-i) is 1 copies its staged value into its active value. Channels whose flag is 0 keep their active value.
- R5: blank_o returns to 0 on the first grayscale-clock rising edge after a sync packet completes. Grayscale-clock edges before completion, including edges while blank_o is high from reset, leave blank_o at 1.
- R6: No output turns on at the releasing grayscale edge. From the next grayscale rising edge, a counter starts at 0 and advances by one per edge, saturating at 2^GS_W-1. Channel i is on while the counter is below its active value, so a value v gives exactly v periods of on-time.
- R7: A packet whose ID differs from dev_id, or whose ID is 0xFF, changes neither blank_o, led_o, staged values, active values nor force mode.
- R8: A force packet (command 3) addressed to this device sets force-on to payload bit 0 (packet bit 32). While force-on is set, led_o[i] is 1 exactly when channel i's active value is non-zero, independent of blank_o and the grayscale clock.
- R9: A write packet (command 2) addressed to this device stores the low GS_W payload bits (the last GS_W packet bits) as the staged value of the channel named by the argument byte. Neither the active values nor led_o change.
- R10: If the serial clock stays idle for IDLE_CYC block-clock cycles in the middle of a packet, the partial packet is discarded and the next bit is taken as bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; oversamples the serial and grayscale clocks |
| rst | input | 1 | Synchronous active-high reset |
| dev_id | input | 8 | This device's address |
| sclk | input | 1 | Serial clock, sampled on its rising edge |
| sin | input | 1 | Serial data in |
| gclk | input | 1 | Grayscale reference clock |
| sout | output | 1 | Serial data to the next device, two bits late |
| blank_o | output | 1 | Internal blanking state |
| led_o | output | NUM_CH | Per-channel constant-current output enables |

## Verification
Every serial or grayscale clock edge takes effect three block-clock cycles after it is driven: two synchroniser stages and one edge register. A result that depends on a decoded packet takes one cycle more. The bench drives inputs at falling block-clock edges and holds each serial or grayscale clock level for four block cycles. It then samples four cycles after a level change, or six cycles after the falling edge of bit 21, which is always past the due cycle and before the next edge. Output on-times are counted in grayscale periods. After every grayscale pulse the bench compares led_o with an arithmetic model of the counter, the active values and the blanking state. That model is advanced by the same stimulus and never by the design.

// File: rtl/ledblank_pkg.sv
package ledblank_pkg;

    localparam int PKT_BITS = 32;
    localparam int ID_W     = 8;
    localparam int CMD_W    = 4;
    localparam int ARG_W    = 8;
    localparam int PAY_W    = PKT_BITS - ID_W - CMD_W - ARG_W;
    localparam int CUT_BIT  = 21;
    localparam logic [ID_W-1:0] NOBODY_ID = 8'hFF;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP   = 4'h0,
        CMD_SYNC  = 4'h1,
        CMD_WRITE = 4'h2,
        CMD_FORCE = 4'h3
    } cmd_e;

    // Field order follows shift order: the first bit shifted lands in the MSB.
    typedef struct packed {
        logic [ID_W-1:0]  id;
        logic [CMD_W-1:0] cmd;
        logic [ARG_W-1:0] arg;
        logic [PAY_W-1:0] payload;
    } pkt_t;

    function automatic logic id_hits(input logic [ID_W-1:0] pid,
                                     input logic [ID_W-1:0] mine);
        return (pid == mine) && (pid != NOBODY_ID);
    endfunction

    function automatic logic sync_head(input logic [ID_W+CMD_W-1:0] head,
                                       input logic [ID_W-1:0] mine);
        return id_hits(head[ID_W+CMD_W-1:CMD_W], mine) &&
               (head[CMD_W-1:0] == CMD_SYNC);
    endfunction

endpackage

// File: rtl/ledblank_sync.sv
module ledblank_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st[0] <= d;
            for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/ledblank_rx.sv
module ledblank_rx
    import ledblank_pkg::*;
#(
    parameter int IDLE_CYC = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sclk_rise,
    input  logic            sclk_fall,
    input  logic            sin_lvl,
    input  logic [ID_W-1:0] dev_id,
    output logic            sout,
    output pkt_t            pkt,
    output logic            cut,
    output logic            done
);
    localparam int CW = $clog2(PKT_BITS);
    localparam int IW = $clog2(IDLE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(PKT_BITS - 1);
    localparam logic [CW-1:0] CUTN = CW'(CUT_BIT);

    logic [PKT_BITS-1:0] sh;
    logic [CW-1:0]       cnt;
    logic [IW-1:0]       idle;
    logic [1:0]          pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            cnt  <= '0;
            idle <= '0;
            pipe <= '0;
            cut  <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= sclk_rise && (cnt == LAST);
            // After CUT_BIT shifts, ID and command sit just below sh[CUT_BIT].
            cut  <= sclk_fall && (cnt == CUTN) &&
                    sync_head(sh[CUT_BIT-1 -: ID_W+CMD_W], dev_id);
            if (sclk_rise) begin
                sh   <= {sh[PKT_BITS-2:0], sin_lvl};
                pipe <= {pipe[0], sin_lvl};
                idle <= '0;
                cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
            end else if (cnt != '0) begin
                if (idle == IW'(IDLE_CYC - 1)) begin
                    cnt  <= '0;
                    idle <= '0;
                end else begin
                    idle <= idle + 1'b1;
                end
            end
        end
    end

    assign sout = pipe[1];
    assign pkt  = pkt_t'(sh);
endmodule

// File: rtl/ledblank_chan.sv
module ledblank_chan #(
    parameter int GS_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [GS_W-1:0] wr_val,
    input  logic            ld_en,
    input  logic            blank,
    input  logic            run,
    input  logic            force_on,
    input  logic [GS_W-1:0] gcnt,
    output logic            led
);
    logic [GS_W-1:0] staged_q, active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged_q <= '0;
            active_q <= '0;
        end else begin
            if (wr_en) staged_q <= wr_val;
            if (ld_en) active_q <= staged_q;
        end
    end

    assign led = force_on ? (active_q != '0)
                          : (!blank && run && (gcnt < active_q));
endmodule

// File: rtl/ledblank_ctrl.sv
module ledblank_ctrl
    import ledblank_pkg::*;
#(
    parameter int NUM_CH      = 12,
    parameter int GS_W        = 4,
    parameter int IDLE_CYC    = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ID_W-1:0]   dev_id,
    input  logic              sclk,
    input  logic              sin,
    input  logic              gclk,
    output logic              sout,
    output logic              blank_o,
    output logic [NUM_CH-1:0] led_o
);
    localparam int SW = 3;
    localparam logic [GS_W-1:0] GMAX = '1;

    logic [SW-1:0] lvl;
    logic [1:0]    prv_q;
    logic          sclk_rise, sclk_fall, gclk_rise;
    pkt_t          pk;
    logic          cut, done, hit;
    logic          do_sync, do_write, do_force;
    logic          blank_q, pend_q, run_q, force_q;
    logic [GS_W-1:0] gcnt_q;

    ledblank_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d({gclk, sclk, sin}), .q(lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) prv_q <= '0;
        else     prv_q <= lvl[2:1];
    end

    assign sclk_rise = lvl[1] & ~prv_q[0];
    assign sclk_fall = ~lvl[1] & prv_q[0];
    assign gclk_rise = lvl[2] & ~prv_q[1];

    ledblank_rx #(.IDLE_CYC(IDLE_CYC)) u_rx (
        .clk(clk), .rst(rst), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .sin_lvl(lvl[0]), .dev_id(dev_id), .sout(sout), .pkt(pk),
        .cut(cut), .done(done)
    );

    assign hit      = id_hits(pk.id, dev_id);
    assign do_sync  = done && hit && (pk.cmd == CMD_SYNC);
    assign do_write = done && hit && (pk.cmd == CMD_WRITE);
    assign do_force = done && hit && (pk.cmd == CMD_FORCE);

    always_ff @(posedge clk) begin
        if (rst) begin
            blank_q <= 1'b1;
            pend_q  <= 1'b0;
            run_q   <= 1'b0;
            force_q <= 1'b0;
            gcnt_q  <= '0;
        end else begin
            if (gclk_rise && pend_q) begin
                blank_q <= 1'b0;
                pend_q  <= 1'b0;
                run_q   <= 1'b0;
                gcnt_q  <= '0;
            end else if (gclk_rise && !blank_q) begin
                if (!run_q)              run_q  <= 1'b1;
                else if (gcnt_q != GMAX) gcnt_q <= gcnt_q + 1'b1;
            end
            if (do_sync)  pend_q  <= 1'b1;
            if (do_force) force_q <= pk.payload[0];
            if (cut) begin
                blank_q <= 1'b1;
                run_q   <= 1'b0;
            end
        end
    end

    assign blank_o = blank_q;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        ledblank_chan #(.GS_W(GS_W)) u_ch (
            .clk(clk), .rst(rst),
            .wr_en(do_write && (pk.arg == ARG_W'(i))),
            .wr_val(pk.payload[GS_W-1:0]),
            .ld_en(do_sync && pk.payload[i]),
            .blank(blank_q), .run(run_q), .force_on(force_q),
            .gcnt(gcnt_q), .led(led_o[i])
        );
    end
endmodule

// File: rtl/ledblank_chk.sv
module ledblank_chk #(
    parameter int NUM_CH = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              blank,
    input logic [NUM_CH-1:0] led,
    input logic              cut,
    input logic              pend,
    input logic              grise,
    input logic              run,
    input logic              force_on
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (blank && led == '0));

    assert_blank_from_cut_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(blank) |-> $past(cut));

    assert_dark_while_blank_R3: assert property (@(posedge clk) disable iff (rst)
        (blank && !force_on) |-> (led == '0));

    assert_pend_only_blanked_R4: assert property (@(posedge clk) disable iff (rst)
        pend |-> blank);

    assert_release_on_gclk_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(blank) |-> $past(grise && pend));

    assert_wait_second_edge_R6: assert property (@(posedge clk) disable iff (rst)
        (!run && !force_on) |-> (led == '0));
endmodule

bind ledblank_ctrl ledblank_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst(rst), .blank(blank_q), .led(led_o), .cut(cut),
    .pend(pend_q), .grise(gclk_rise), .run(run_q), .force_on(force_q)
);

// File: tb/sim_ledblank_ctrl.sv
module sim_ledblank_ctrl;
    localparam int NCH = 12;
    localparam logic [7:0] DEV = 8'h5A;

    logic clk = 1'b0, rst = 1'b1, sclk = 1'b0, sin = 1'b0, gclk = 1'b0;
    logic sout, blank_o;
    logic [NCH-1:0] led_o;

    int checks = 0, errors = 0;
    bit finished = 0;

    logic [3:0] act_m [NCH];
    logic [3:0] stg_m [NCH];
    bit blank_m = 1, pend_m = 0, run_m = 0, force_m = 0;
    int g_m = 0;
    logic last_bit = 1'b0;

    always #10 clk = ~clk;

    ledblank_ctrl u0 (
        .clk(clk), .rst(rst), .dev_id(DEV), .sclk(sclk), .sin(sin),
        .gclk(gclk), .sout(sout), .blank_o(blank_o), .led_o(led_o)
    );

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [NCH-1:0] cur_led();
        logic [NCH-1:0] l;
        for (int c = 0; c < NCH; c++)
            l[c] = force_m ? (act_m[c] != 4'd0)
                           : (run_m && !blank_m && (g_m < int'(act_m[c])));
        return l;
    endfunction

    function automatic logic [31:0] mk(input logic [7:0] id, input logic [3:0] cmd,
                                       input logic [7:0] arg, input logic [11:0] pay);
        return {id, cmd, arg, pay};
    endfunction

    // Rising half of one serial bit, with the two-bit pass-through check (R2).
    task automatic bit_rise(input logic b);
        sin = b;
        clks(4);
        sclk = 1'b1;
        clks(4);
        chk("R2", sout, last_bit);
        last_bit = b;
    endtask

    task automatic send_pkt(input logic [31:0] p);
        logic [7:0] id;
        logic [3:0] cmd;
        logic [7:0] arg;
        logic [11:0] pay;
        bit own, is_sync;
        string tag;
        id = p[31:24]; cmd = p[23:20]; arg = p[19:12]; pay = p[11:0];
        own = (id == DEV) && (id != 8'hFF);
        is_sync = own && (cmd == 4'd1);
        if (!own)              tag = "R7";
        else if (cmd == 4'd1)  tag = "R4";
        else if (cmd == 4'd2)  tag = "R9";
        else if (cmd == 4'd3)  tag = "R8";
        else                   tag = "R7";
        for (int b = 1; b <= 32; b++) begin
            bit_rise(p[32-b]);
            if (b == 21) begin
                chk(is_sync ? "R3" : tag, blank_o, blank_m);
                chk(is_sync ? "R3" : tag, led_o, cur_led());
            end
            sclk = 1'b0;
            if (b == 21) begin
                if (is_sync) begin blank_m = 1; run_m = 0; end
                clks(6);
                chk(is_sync ? "R3" : tag, blank_o, blank_m);
                chk(is_sync ? "R3" : tag, led_o, cur_led());
            end else begin
                clks(4);
            end
        end
        clks(6);
        if (own) begin
            case (cmd)
                4'd1: begin
                    for (int c = 0; c < NCH; c++) if (pay[c]) act_m[c] = stg_m[c];
                    pend_m = 1;
                end
                4'd2: if (arg < 8'(NCH)) stg_m[arg] = pay[3:0];
                4'd3: force_m = pay[0];
                default: ;
            endcase
        end
        chk(tag, blank_o, blank_m);
        chk(tag, led_o, cur_led());
    endtask

    task automatic gpulse();
        string tag;
        gclk = 1'b1;
        clks(4);
        gclk = 1'b0;
        clks(4);
        if (pend_m) begin
            blank_m = 0; pend_m = 0; run_m = 0; g_m = 0; tag = "R5";
        end else if (!blank_m) begin
            if (!run_m) run_m = 1;
            else if (g_m < 15) g_m++;
            tag = "R6";
        end else begin
            tag = "R5";
        end
        chk(tag, blank_o, blank_m);
        chk(tag, led_o, cur_led());
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) begin act_m[c] = 4'd0; stg_m[c] = 4'd0; end
        clks(5);
        chk("R1", blank_o, 1'b1);
        chk("R1", led_o, '0);
        chk("R1", sout, 1'b0);
        rst = 1'b0;
        clks(1);
        chk("R1", blank_o, 1'b1);
        chk("R1", led_o, '0);
        clks(3);

        // R5: grayscale edges while blanked from reset do not release.
        gpulse();
        gpulse();

        // R6/R4/R9: sweep every grayscale value through the channels.
        for (int v = 0; v < 16; v++) begin
            send_pkt(mk(DEV, 4'd2, 8'(v % NCH), 12'(v)));
            send_pkt(mk(DEV, 4'd1, 8'h00, 12'(1 << (v % NCH))));
            repeat (18) gpulse();
        end

        // R4: several channels staged, a subset flagged.
        for (int c = 0; c < NCH; c++)
            send_pkt(mk(DEV, 4'd2, 8'(c), 12'((c * 5 + 3) % 16)));
        send_pkt(mk(DEV, 4'd1, 8'h00, 12'hA5C));
        repeat (4) gpulse();
        // R3: sync arriving while outputs are on blanks them at bit 21.
        send_pkt(mk(DEV, 4'd1, 8'h00, 12'h000));
        repeat (6) gpulse();

        // R7: foreign and unused-ID packets change nothing.
        send_pkt(mk(DEV ^ 8'h01, 4'd2, 8'd3, 12'h00F));
        send_pkt(mk(8'hFF, 4'd2, 8'd4, 12'h00E));
        send_pkt(mk(DEV ^ 8'h80, 4'd1, 8'h00, 12'hFFF));
        send_pkt(mk(8'hFF, 4'd1, 8'h00, 12'hFFF));
        send_pkt(mk(8'hFF, 4'd3, 8'h00, 12'h001));
        send_pkt(mk(DEV, 4'd0, 8'h00, 12'hFFF));
        chk("R7", blank_o, 1'b0);
        send_pkt(mk(DEV, 4'd1, 8'h00, 12'hFFF));
        repeat (5) gpulse();

        // R8: force-on ignores blanking and the grayscale clock.
        send_pkt(mk(DEV, 4'd3, 8'h00, 12'h001));
        chk("R8", led_o, cur_led());
        repeat (3) gpulse();
        send_pkt(mk(DEV, 4'd1, 8'h00, 12'h000));
        chk("R8", blank_o, 1'b1);
        send_pkt(mk(DEV, 4'd3, 8'h00, 12'h000));
        chk("R8", led_o, '0);
        repeat (5) gpulse();

        // R10: an abandoned partial packet is dropped after an idle gap.
        for (int b = 0; b < 13; b++) begin
            bit_rise(1'(b & 1));
            sclk = 1'b0;
            clks(4);
        end
        clks(100);
        send_pkt(mk(DEV, 4'd2, 8'd7, 12'h009));
        send_pkt(mk(DEV, 4'd1, 8'h00, 12'h080));
        chk("R10", blank_o, 1'b1);
        gpulse();
        chk("R10", blank_o, 1'b0);
        repeat (6) gpulse();
        chk("R10", {28'd0, 4'(led_o[7])}, {28'd0, 4'(g_m < 9)});

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule